// File: doc/BRIEF.md
# Timestamp Event Interrupt Aggregator

This block collects nine single-cycle event pulses from a precision-time-protocol timestamping unit and turns them into one system interrupt through two levels of gating. The sources are a timer event, two GPIO capture events, and a transmit and a receive timestamp capture on each of three switch ports: host port, port 1 and port 2. Each source sets a sticky status bit whether or not it is enabled. Software clears a status bit by writing 1 to it, and makes a source eligible through a per-source enable bit. The status and enable bits sit together in one 32-bit event word.

The OR of every enabled status bit appears as a read-only cascade bit in a top-level status word. A matching top-level enable bit must also be set before the interrupt line rises. All registers sit behind a simple single-cycle register port. Writes take effect at the clock edge, and reads return data combinationally for the address currently presented. Packet matching and clock capture are outside this block.

Top module: `ptp_evt_irq_agg`

## Requirements
- R1: After reset, every status bit, source enable and top-level enable is 0. All three words read 0 and `irq_o` is low.
- R2: A pulse on `src_evt[n]` sets status bit n of the event word (address 0x198) at the next edge, whether or not its enable is set.
- R3: Writing the event word clears each status bit (bits 8:0) whose data bit is 1. Status bits written with 0 keep their value.
- R4: If a source pulse and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R5: Enable bits 24:16 are plain read/write bits. Every write to the event word loads them from the data bits 24:16.
- R6: Bits 31:25 and 15:9 of the event word always read 0, and writes to them have no effect.
- R7: Bit 29 of the top-level status word (address 0x058) reads 1 exactly when at least one status bit n is set together with enable bit n+16. Writes to this word have no effect, and all its other bits read 0.
- R8: Bit 29 of the top-level enable word (address 0x05C) is read/write, and its other bits read 0. `irq_o` is high exactly when this bit and the cascade bit are both 1.
- R9: Any address other than the three above reads 0.
- R10: Source index order is timer (0), GPIO capture A (1), GPIO capture B (2), host TX (3), host RX (4), port 1 TX (5), port 1 RX (6), port 2 TX (7), port 2 RX (8). Status bit n pairs with enable bit n+16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address of the word to access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| src_evt | input | 9 | Per-source event pulses, index order as in R10 |
| irq_o | output | 1 | System interrupt line |

## Verification
The bench builds the block with its default parameters: nine sources, enables starting at bit 16, cascade bit 29, and the combinational interrupt variant. With these values every source can be tested alone against its own enable and its pairing can be checked. Collisions between a source pulse and a clear of the same bit are reachable in the same cycle. A behavioural model then follows a long random mix of pulses, writes, and reads of all three words plus an unmapped address. It compares the read data and the interrupt line on every cycle.

// File: rtl/ptp_irq_pkg.sv
package ptp_irq_pkg;
   // Source index order; status bit n pairs with enable bit n + EN_LSB
   typedef enum logic [3:0] {
      SRC_TIMER   = 4'd0,
      SRC_GPIO_A  = 4'd1,
      SRC_GPIO_B  = 4'd2,
      SRC_HOST_TX = 4'd3,
      SRC_HOST_RX = 4'd4,
      SRC_P1_TX   = 4'd5,
      SRC_P1_RX   = 4'd6,
      SRC_P2_TX   = 4'd7,
      SRC_P2_RX   = 4'd8
   } src_idx_e;

   localparam int unsigned NUM_SOURCES = 9;
   localparam int unsigned WORD_W      = 32;
endpackage

// File: rtl/ptp_irq_sticky.sv
module ptp_irq_sticky #(
   parameter int unsigned N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] sts_o
);
   initial begin : elab_chk
      assert (N >= 1) else $error("ptp_irq_sticky: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q <= 1'b0;
         else if (set_i[i]) q <= 1'b1;   // event wins over a clear
         else if (clr_i[i]) q <= 1'b0;
      end
      assign sts_o[i] = q;

      // R2: an event always leaves the bit set
      a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> sts_o[i]);
      // R3: a clear without a competing event empties the bit
      a_r3_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
         clr_i[i] && !set_i[i] |=> !sts_o[i]);
      // R4: set bit survives when a clear meets an event, or when no clear arrives
      a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
         sts_o[i] && (!clr_i[i] || set_i[i]) |=> sts_o[i]);
   end
endmodule

// File: rtl/ptp_irq_cascade.sv
module ptp_irq_cascade #(
   parameter int unsigned N       = 9,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sts_i,
   input  logic [N-1:0] en_i,
   input  logic         top_en_i,
   output logic         casc_o,
   output logic         irq_o
);
   logic irq_d;

   assign casc_o = |(sts_i & en_i);
   assign irq_d  = casc_o & top_en_i;

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_d;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_d;
   end
endmodule

// File: rtl/ptp_evt_irq_agg.sv
module ptp_evt_irq_agg
   import ptp_irq_pkg::*;
#(
   parameter int unsigned NSRC        = NUM_SOURCES,
   parameter int unsigned DATA_W      = WORD_W,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned EN_LSB      = 16,
   parameter int unsigned CASC_BIT    = 29,
   parameter logic [ADDR_W-1:0] EVT_ADDR    = 12'h198,
   parameter logic [ADDR_W-1:0] TOP_STS_ADDR = 12'h058,
   parameter logic [ADDR_W-1:0] TOP_EN_ADDR  = 12'h05C,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NSRC-1:0]   src_evt,
   output logic              irq_o
);
   localparam int unsigned EN_MSB = EN_LSB + NSRC - 1;

   initial begin : elab_chk
      assert (NSRC <= EN_LSB) else $error("status field overlaps enable field");
      assert (EN_MSB < DATA_W) else $error("enable field exceeds word");
      assert (CASC_BIT < DATA_W) else $error("cascade bit exceeds word");
      assert (EVT_ADDR != TOP_STS_ADDR && EVT_ADDR != TOP_EN_ADDR &&
              TOP_STS_ADDR != TOP_EN_ADDR) else $error("address clash");
   end

   logic            wr_evt, wr_top_en;
   logic [NSRC-1:0] clr_req, sts, en_q;
   logic            top_en_q, casc;
   logic            unused_wdata;

   assign wr_evt    = reg_we && (reg_addr == EVT_ADDR);
   assign wr_top_en = reg_we && (reg_addr == TOP_EN_ADDR);
   assign clr_req   = wr_evt ? reg_wdata[NSRC-1:0] : '0;
   assign unused_wdata = ^reg_wdata;

   ptp_irq_sticky #(.N(NSRC)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (src_evt),
      .clr_i (clr_req),
      .sts_o (sts)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         top_en_q <= 1'b0;
      end else begin
         if (wr_evt)    en_q     <= reg_wdata[EN_MSB:EN_LSB];
         if (wr_top_en) top_en_q <= reg_wdata[CASC_BIT];
      end
   end

   ptp_irq_cascade #(.N(NSRC), .IRQ_REG(IRQ_REG)) u_casc (
      .clk      (clk),
      .rst_n    (rst_n),
      .sts_i    (sts),
      .en_i     (en_q),
      .top_en_i (top_en_q),
      .casc_o   (casc),
      .irq_o    (irq_o)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == EVT_ADDR) begin
         reg_rdata[NSRC-1:0]     = sts;
         reg_rdata[EN_MSB:EN_LSB] = en_q;
      end else if (reg_addr == TOP_STS_ADDR) begin
         reg_rdata[CASC_BIT] = casc;
      end else if (reg_addr == TOP_EN_ADDR) begin
         reg_rdata[CASC_BIT] = top_en_q;
      end
   end

   // R5: an event-word write loads the enables
   a_r5_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> en_q == $past(reg_wdata[EN_MSB:EN_LSB]));
   // R7: with no event and no event-word write the cascade cannot rise
   a_r7_no_spurious_casc: assert property (@(posedge clk) disable iff (!rst_n)
      !casc && !(|src_evt) && !wr_evt |=> !casc);

   if (!IRQ_REG) begin : g_irq_chk
      // R8: dropping the top-level enable silences the line
      a_r8_top_gate: assert property (@(posedge clk) disable iff (!rst_n)
         wr_top_en && !reg_wdata[CASC_BIT] |=> !irq_o);
   end
endmodule

// File: tb/tb_ptp_evt_irq_agg.sv
`timescale 1ns/1ps
module tb_ptp_evt_irq_agg;
   localparam logic [11:0] A_EVT = 12'h198;
   localparam logic [11:0] A_TS  = 12'h058;
   localparam logic [11:0] A_TE  = 12'h05C;
   localparam logic [11:0] A_BAD = 12'h100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [8:0]  src_evt = '0;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int unsigned m_sts = 0, m_en = 0, m_te = 0;
   logic [31:0] last_rd;
   logic        last_irq;

   always #4 clk = ~clk;

   ptp_evt_irq_agg dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_evt(src_evt),
      .irq_o(irq_o)
   );

   function automatic logic [31:0] m_read(logic [11:0] a);
      int unsigned hit;
      hit = ((m_sts & m_en) != 0) ? 1 : 0;
      if (a == A_EVT) return 32'(m_sts | (m_en << 16));
      if (a == A_TS)  return 32'(hit << 29);
      if (a == A_TE)  return 32'(m_te << 29);
      return 32'h0;
   endfunction

   function automatic logic m_irq();
      return ((m_sts & m_en) != 0) && (m_te != 0);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle: drive, compare against model, then advance model past the edge
   task automatic step(logic we, logic [11:0] a, logic [31:0] d, logic [8:0] ev);
      @(negedge clk);
      reg_we = we; reg_addr = a; reg_wdata = d; src_evt = ev;
      #1;
      last_rd  = reg_rdata;
      last_irq = irq_o;
      chk("R9 model read", reg_rdata, m_read(a));
      chk("R8 model irq", {31'b0, irq_o}, {31'b0, m_irq()});
      @(posedge clk);
      if (we && a == A_EVT) begin
         m_sts = m_sts & ~(d & 32'h1FF);
         m_en  = (d >> 16) & 32'h1FF;
      end
      if (we && a == A_TE) m_te = d[29];
      m_sts = m_sts | ev;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state
      step(0, A_EVT, 0, 0); chk("R1 evt", last_rd, 32'h0);
      chk("R1 irq", {31'b0, last_irq}, 32'h0);
      step(0, A_TS, 0, 0);  chk("R1 top sts", last_rd, 32'h0);
      step(0, A_TE, 0, 0);  chk("R1 top en", last_rd, 32'h0);

      // R2 disabled source still sets status
      step(0, A_EVT, 0, 9'h020);
      step(0, A_EVT, 0, 0); chk("R2 status set", last_rd, 32'h0000_0020);
      step(0, A_TS, 0, 0);  chk("R2 no cascade", last_rd, 32'h0);

      // R3 writing 0 keeps, writing 1 clears
      step(1, A_EVT, 32'h0, 0);
      step(0, A_EVT, 0, 0); chk("R3 zero keeps", last_rd, 32'h0000_0020);
      step(1, A_EVT, 32'h0000_0020, 0);
      step(0, A_EVT, 0, 0); chk("R3 one clears", last_rd, 32'h0);

      // R5 / R6 enables read back, reserved bits stay 0
      step(1, A_EVT, 32'hFFFF_FE00, 0);
      step(0, A_EVT, 0, 0); chk("R5 R6 enables", last_rd, 32'h01FF_0000);

      // R7 cascade reflects enabled status; R8 gated by top enable
      step(0, A_EVT, 0, 9'h001);
      step(0, A_TS, 0, 0); chk("R7 cascade", last_rd, 32'h2000_0000);
      chk("R8 gated off", {31'b0, last_irq}, 32'h0);
      step(1, A_TE, 32'hFFFF_FFFF, 0);
      step(0, A_TE, 0, 0); chk("R8 top en", last_rd, 32'h2000_0000);
      chk("R8 irq on", {31'b0, last_irq}, 32'h1);
      step(1, A_TS, 32'h0, 0);
      step(0, A_TS, 0, 0); chk("R7 read only", last_rd, 32'h2000_0000);

      // R4 event and clear collide on bit 0
      step(1, A_EVT, 32'h01FF_0001, 9'h001);
      step(0, A_EVT, 0, 0); chk("R4 event wins", last_rd, 32'h01FF_0001);
      step(1, A_EVT, 32'h01FF_0001, 0);
      step(0, A_TS, 0, 0); chk("R7 drops", last_rd, 32'h0);
      chk("R8 irq off", {31'b0, last_irq}, 32'h0);

      // R10 pairing: each source alone with only its own enable
      for (int n = 0; n < 9; n++) begin
         step(1, A_EVT, 32'h1 << (16 + ((n + 1) % 9)), 0);
         step(0, A_EVT, 0, 9'(1 << n));
         step(0, A_EVT, 0, 0);
         chk("R10 status pos", last_rd & 32'h1FF, 32'h1 << n);
         chk("R10 other enable", {31'b0, last_irq}, 32'h0);
         step(1, A_EVT, 32'h1 << (16 + n), 0);
         step(0, A_EVT, 0, 0);
         chk("R10 own enable", {31'b0, last_irq}, 32'h1);
         step(1, A_EVT, 32'h1 << n, 0);
      end

      // R9 unmapped address
      step(0, A_BAD, 0, 0); chk("R9 unmapped", last_rd, 32'h0);

      // random mix compared cycle by cycle with the model
      for (int k = 0; k < 2000; k++) begin
         logic [11:0] a;
         int sel;
         sel = $urandom_range(0, 3);
         a = (sel == 0) ? A_EVT : (sel == 1) ? A_TS : (sel == 2) ? A_TE : A_BAD;
         step(($urandom_range(0, 3) == 0), a, $urandom,
              ($urandom_range(0, 2) == 0) ? 9'($urandom) : 9'h0);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule